// File: doc/BRIEF.md
# Dual-Mode Noise Bit Generator

This block makes the one-bit noise waveform of a sound channel. A 4-bit rate index selects a period from a fixed sixteen-entry table. That period loads an 11-bit down-counting timer, which advances on a CPU-rate clock enable. The timer produces a terminal-count pulse each time it wraps. A divide-by-two stage passes on every second pulse, and each pulse it passes shifts a 15-bit linear feedback register by one place. The waveform is the inverted top bit of that register.

A mode bit selects one of two feedback tap pairs. The long mode runs a maximal sequence of 32767 states, and the short mode runs a 93-state loop. The rate index and the mode bit arrive together through a single-cycle write strobe. They are held as a pending setting and take effect only when the timer next reloads, so a write never cuts a timer period short and never alters the shift register. Volume, envelope, length counting and conversion to analog are handled outside this block.

Top module: `noise_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block takes its reset state: shift register 1, divide-by-two phase cleared, timer count 0, pending and active setting equal to rate index 0 and long mode. In this state `noise_out` is 1. The first enabled cycle after reset therefore produces a terminal count.
- R2: The timer period, counted in enabled cycles (`cpu_en` high), is set by the rate index. For indices 0 through 15 the periods are, in hex, 002, 004, 008, 010, 020, 030, 040, 050, 065, 07F, 0BE, 0FE, 17D, 1FC, 3F9 and 7F2. The timer loads the period minus one and reloads when it reaches zero.
- R3: The shift register advances once for every two terminal counts, on the second pulse of each pair counted from reset.
- R4: On each shift, the register moves one place toward bit 14 and the feedback bit enters bit 0. `noise_out` is the inverse of bit 14. After reset, with the rate set before the first enable, `noise_out` first drops to 0 on enabled cycle 1 + 27·P, where P is the period.
- R5: With `wr_mode` = 0 (long mode), the feedback is bit 14 XOR bit 13. The register state first returns to its reset value after exactly 32767 shifts.
- R6: With `wr_mode` = 1 (short mode), the feedback is bit 14 XOR bit 8. The register state first returns to its reset value after exactly 93 shifts.
- R7: A write (`wr_en` high) stores `wr_rate` and `wr_mode` as the pending setting. The timer uses the pending setting only at its next reload, and a write never changes the shift register.
- R8: In a cycle with `cpu_en` low, the timer, the phase and the register all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_en | input | 1 | CPU-rate clock enable |
| wr_en | input | 1 | Write strobe for the setting |
| wr_rate | input | 4 | Rate index into the period table |
| wr_mode | input | 1 | Sequence mode: 0 long, 1 short |
| noise_out | output | 1 | Noise bit, the inverse of shift-register bit 14 |

## Verification
Every timing result is counted in enabled cycles. The terminal count is combinational on the enabled cycle whose count is zero, and the shift register updates at that same edge. A result caused by enabled cycle k is therefore visible at the falling edge that follows edge k. The bench drives its inputs and samples `noise_out` only on falling edges, and it counts enables at those points. Each expected drop time, 1 + 27·P, follows from 28 terminal counts. Each sequence length is found with a 15-bit window of output samples, one sample taken three enables after reset and then every four enables at the fastest rate. Fifteen consecutive outputs fix the whole register state, so the window can detect when the state repeats.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int LFSR_W = 15;
    localparam int TMR_W  = 11;
    localparam int IDX_W  = 4;

    typedef enum logic {
        SEQ_LONG  = 1'b0,
        SEQ_SHORT = 1'b1
    } seq_mode_t;

    typedef struct packed {
        logic [IDX_W-1:0] rate;
        seq_mode_t        mode;
    } noise_cfg_t;

    // Reload value (period minus one) for each rate index
    function automatic logic [TMR_W-1:0] reload_of(input logic [IDX_W-1:0] idx);
        logic [TMR_W-1:0] r;
        case (idx)
            4'h0: r = 11'h001;
            4'h1: r = 11'h003;
            4'h2: r = 11'h007;
            4'h3: r = 11'h00F;
            4'h4: r = 11'h01F;
            4'h5: r = 11'h02F;
            4'h6: r = 11'h03F;
            4'h7: r = 11'h04F;
            4'h8: r = 11'h064;
            4'h9: r = 11'h07E;
            4'hA: r = 11'h0BD;
            4'hB: r = 11'h0FD;
            4'hC: r = 11'h17C;
            4'hD: r = 11'h1FB;
            4'hE: r = 11'h3F8;
            default: r = 11'h7F1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/noise_timer.sv
module noise_timer
    import noise_pkg::*;
#(
    parameter int CNT_W = TMR_W,
    parameter int SEL_W = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEL_W-1:0] rate_next,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;

    assign tc = tick && (cnt == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else if (tick) begin
            if (cnt == ZERO) cnt <= CNT_W'(reload_of(IDX_W'(rate_next)));
            else             cnt <= cnt - ONE;
        end
    end

    AST_TIMER_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != ZERO) |=> (cnt == $past(cnt) - ONE)); // R2
    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tc |=> (cnt == CNT_W'(reload_of(IDX_W'($past(rate_next)))))); // R2
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R8

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
#(
    parameter int W         = LFSR_W,
    parameter int LONG_TAP  = 13,
    parameter int SHORT_TAP = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tc,
    input  seq_mode_t mode,
    output logic      msb
);
    localparam logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sr;
    logic         phase;
    logic         shift;
    logic         fb;

    assign shift = tc && phase;
    assign fb    = sr[W-1] ^ ((mode == SEQ_SHORT) ? sr[SHORT_TAP] : sr[LONG_TAP]);
    assign msb   = sr[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (tc) begin
            phase <= ~phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= SEED;
        end else if (shift) begin
            sr <= {sr[W-2:0], fb};
        end
    end

    AST_SEED_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (sr == SEED && !phase)); // R1
    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        tc |=> (phase != $past(phase))); // R3
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(sr)); // R3
    AST_LFSR_MOVES_UP: assert property (@(posedge clk) disable iff (rst)
        shift |=> (sr[W-1:1] == $past(sr[W-2:0]))); // R4
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        sr != '0); // R5

endmodule

// File: rtl/noise_gen.sv
module noise_gen
    import noise_pkg::*;
#(
    parameter int SR_W      = LFSR_W,
    parameter int LONG_TAP  = 13,
    parameter int SHORT_TAP = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_en,
    input  logic       wr_en,
    input  logic [3:0] wr_rate,
    input  logic       wr_mode,
    output logic       noise_out
);
    localparam noise_cfg_t CFG_RST = '{rate: '0, mode: SEQ_LONG};

    noise_cfg_t pend_cfg;
    seq_mode_t  act_mode;
    logic       tc;
    logic       msb;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg <= CFG_RST;
        end else if (wr_en) begin
            pend_cfg <= '{rate: IDX_W'(wr_rate), mode: seq_mode_t'(wr_mode)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= SEQ_LONG;
        end else if (tc) begin
            act_mode <= pend_cfg.mode;
        end
    end

    noise_timer #(.CNT_W(TMR_W), .SEL_W(IDX_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (cpu_en),
        .rate_next (pend_cfg.rate),
        .tc        (tc)
    );

    noise_lfsr #(.W(SR_W), .LONG_TAP(LONG_TAP), .SHORT_TAP(SHORT_TAP)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .tc   (tc),
        .mode (act_mode),
        .msb  (msb)
    );

    assign noise_out = ~msb;

    AST_MODE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !tc |=> $stable(act_mode)); // R7
    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |=> $stable(noise_out)); // R8

endmodule

// File: tb/test_noise_gen.sv
module test_noise_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_en;
    logic       wr_en;
    logic [3:0] wr_rate;
    logic       wr_mode;
    logic       noise_out;

    int total = 0;
    int bad   = 0;

    localparam int WATCHDOG = 198000;
    localparam int NRATES   = 12;
    // Periods in enabled cycles for rate indices 0..11 (R2)
    localparam int PER [0:NRATES-1] = '{2, 4, 8, 16, 32, 48, 64, 80, 101, 127, 190, 254};

    always #2.5 clk = ~clk;

    noise_gen i_noise_gen (
        .clk       (clk),
        .rst       (rst),
        .cpu_en    (cpu_en),
        .wr_en     (wr_en),
        .wr_rate   (wr_rate),
        .wr_mode   (wr_mode),
        .noise_out (noise_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_en = 1'b0; wr_en = 1'b0; wr_rate = '0; wr_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] r, input logic m);
        wr_en = 1'b1; wr_rate = r; wr_mode = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count enabled cycles until noise_out drops, cpu_en held high
    task automatic enables_to_fall(input int limit, output int n);
        n = 0;
        cpu_en = 1'b1;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (!noise_out) break;
        end
        cpu_en = 1'b0;
    endtask

    // Shifts until the register state first repeats, at rate 0
    task automatic seq_length(input logic m, input int limit, output int len);
        logic [14:0] ref_w;
        logic [14:0] win;
        int j;
        do_reset();
        write_cfg(4'h0, m);
        win = 15'(noise_out);
        ref_w = '0;
        len = -1;
        cpu_en = 1'b1;
        repeat (3) @(negedge clk);
        j = 1;
        while (j < limit) begin
            win = {win[13:0], noise_out};
            if (j == 14) ref_w = win;
            else if (j > 14 && win == ref_w) begin
                len = j - 14;
                break;
            end
            repeat (4) @(negedge clk);
            j++;
        end
        cpu_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int len;
        rst = 1'b1; cpu_en = 1'b0; wr_en = 1'b0; wr_rate = '0; wr_mode = 1'b0;

        // R1: reset state
        do_reset();
        check(noise_out == 1'b1, "R1 reset output", int'(noise_out), 1);
        // R1: defaults rate 0 long; first fall at 1+27*2
        enables_to_fall(5000, n);
        check(n == 55, "R1 default rate", n, 55);

        // R2 R3 R4: table of rate vectors, expected fall at 1+27*P
        for (int i = 0; i < NRATES; i++) begin
            do_reset();
            write_cfg(4'(i), 1'b0);
            enables_to_fall(10000, n);
            check(n == 1 + 27 * PER[i], $sformatf("R2 R4 rate %0d", i), n, 1 + 27 * PER[i]);
        end

        // R7: rate change mid-period waits for reload; output untouched by write
        do_reset();
        write_cfg(4'hF, 1'b0);
        cpu_en = 1'b1;
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_rate = 4'h0; wr_mode = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check(noise_out == 1'b1, "R7 write keeps register", int'(noise_out), 1);
        enables_to_fall(5000, n);
        n = n + 6;
        check(n == 1 + 2034 + 26 * 2, "R7 rate at reload", n, 2087);

        // R8: no progress with cpu_en low
        do_reset();
        write_cfg(4'h1, 1'b0);
        repeat (300) @(negedge clk);
        check(noise_out == 1'b1, "R8 idle hold", int'(noise_out), 1);
        enables_to_fall(5000, n);
        check(n == 109, "R8 enables counted", n, 109);

        // R1: reset mid-run restores seed
        do_reset();
        write_cfg(4'h0, 1'b1);
        cpu_en = 1'b1;
        repeat (70) @(negedge clk);
        cpu_en = 1'b0;
        do_reset();
        check(noise_out == 1'b1, "R1 reset mid-run", int'(noise_out), 1);

        // R6: short sequence length
        seq_length(1'b1, 1000, len);
        check(len == 93, "R6 short length", len, 93);

        // R5: long sequence length
        seq_length(1'b0, 33000, len);
        check(len == 32767, "R5 long length", len, 32767);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule